// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This unit sits beside a cache and services its misses one at a time. When a miss arrives, the unit first looks at the oldest entry of a small FIFO of prefetched block addresses. If that entry matches, the block is handed to the cache from the FIFO and no demand read goes to memory. If it does not match, the FIFO is emptied, the missed block is read from memory as a demand request, and prefetching starts again at the block after the miss.

Prefetched blocks are never written into the cache on their own. They wait in the FIFO until a later miss asks for them. Each time a block leaves the FIFO, the free slot is refilled with the block one past the newest entry. This keeps a sequential stream running ahead of the cache. Memory is reached through a request port with a ready input and an in-order response port. Demand reads always win that port over prefetches.

All addresses are block addresses. The FIFO depth is a parameter.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset, `miss_ready` is 1, `fill_valid` is 0 and no memory request is presented. Prefetching stays disabled until the first miss has been accepted.
- R2: A miss is accepted when `miss_valid` and `miss_ready` are both 1 at a clock edge. If it does not match the oldest FIFO entry (or the FIFO is empty), a demand request (`mem_req_prefetch`=0) for the miss address is presented from the next cycle on, and held until `mem_req_ready` takes it.
- R3: No prefetch request is presented from the cycle a non-matching miss is presented and accepted until its demand request has been taken.
- R4: After a non-matching miss at address A, prefetch addresses start at A+1. Each taken prefetch is followed by the next address, modulo 2^ADDR_W.
- R5: The FIFO holds at most DEPTH entries. One entry is held for each prefetch taken since the last flush and not yet handed to the cache, and a prefetch is presented only while fewer than DEPTH are held.
- R6: Responses arrive in request order. A response to a prefetch taken before a flush is dropped and never reaches the cache, and fill data always equals the memory contents of `fill_addr`.
- R7: The response to a demand request is shown on the fill port one cycle later, with `fill_from_buf`=0 and `fill_addr` equal to the miss address.
- R8: A miss that matches the oldest entry causes no demand request. Its fill has `fill_from_buf`=1 and carries the data returned for that prefetch.
- R9: For a matching miss accepted at edge a, whose entry's data is taken at edge t, the fill is shown after edge max(a,t)+1. An entry still waiting for data counts as a match.
- R10: `miss_ready` is 1 exactly when no miss is in service. Each accepted miss produces exactly one single-cycle fill.
- R11: A prefetch is presented whenever all of these hold: prefetching is enabled, no demand request is waiting, no non-matching miss is being accepted this cycle, and fewer than DEPTH entries are held.
- R12: DEPTH is a parameter meant for the values 1, 4 and 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Cache presents a miss |
| miss_addr | input | ADDR_W | Block address of the miss |
| miss_ready | output | 1 | Unit can accept a miss |
| fill_valid | output | 1 | One-cycle fill strobe to the cache |
| fill_addr | output | ADDR_W | Block address being filled |
| fill_data | output | DATA_W | Block contents |
| fill_from_buf | output | 1 | 1 if the block came from the FIFO, 0 if from a demand read |
| mem_req_valid | output | 1 | Memory request presented; an untaken request may change next cycle |
| mem_req_addr | output | ADDR_W | Block address requested |
| mem_req_prefetch | output | 1 | 1 for a prefetch, 0 for a demand read |
| mem_req_ready | input | 1 | Memory takes the presented request at this edge |
| mem_rsp_valid | input | 1 | In-order response strobe |
| mem_rsp_data | input | DATA_W | Response block contents |

## Verification
The bench builds the unit with DEPTH=4, ADDR_W=16 and DATA_W=32, behind a memory with a three-cycle response latency. With these values the FIFO fills up during a single demand read, so the top-up after each match can be observed. Misses issued back-to-back hit entries whose data is still in flight, while spaced misses hit entries whose data has already arrived. An address jump while prefetches are outstanding leaves stale responses that must be dropped. The 16-bit address makes the wrap from 0xFFFF to 0x0000 easy to reach. A throttled ready pattern holds demand requests waiting long enough to show that prefetches stay off the port during that time.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BUFWAIT = 2'd1,
        ST_DEMREQ  = 2'd2,
        ST_DEMWAIT = 2'd3
    } sbp_state_e;

    typedef enum logic [1:0] {
        RSP_NONE   = 2'd0,
        RSP_DROP   = 2'd1,
        RSP_DEMAND = 2'd2,
        RSP_PREF   = 2'd3
    } sbp_rsp_e;

    function automatic int idx_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    function automatic int cnt_bits(input int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/sbp_entry_store.sv
module sbp_entry_store import sbp_pkg::*; #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  logic                          push,
    input  logic [ADDR_W-1:0]             push_tag,
    input  logic                          fill_en,
    input  logic [DATA_W-1:0]             fill_data,
    input  logic                          pop,
    output logic [cnt_bits(DEPTH)-1:0]    count,
    output logic [cnt_bits(DEPTH)-1:0]    filled,
    output logic                          full,
    output logic [ADDR_W-1:0]             head_tag,
    output logic [DATA_W-1:0]             head_data
);
    localparam int IW = idx_bits(DEPTH);
    localparam int CW = cnt_bits(DEPTH);

    logic [IW-1:0]     head_q;
    logic [CW-1:0]     count_q, filled_q;
    logic [ADDR_W-1:0] tag_q  [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [IW-1:0]     tail_idx, fill_idx;

    function automatic logic [IW-1:0] adv(input logic [IW-1:0] p, input logic [CW-1:0] n);
        int s;
        s = int'(p) + int'(n);
        if (s >= DEPTH) s = s - DEPTH;
        return IW'(s);
    endfunction

    assign tail_idx  = adv(head_q, count_q);
    assign fill_idx  = adv(head_q, filled_q);
    assign count     = count_q;
    assign filled    = filled_q;
    assign full      = (count_q == CW'(DEPTH));
    assign head_tag  = tag_q[head_q];
    assign head_data = data_q[head_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q   <= '0;
            count_q  <= '0;
            filled_q <= '0;
        end else if (flush) begin
            count_q  <= '0;
            filled_q <= '0;
        end else begin
            if (pop) head_q <= adv(head_q, CW'(1));
            count_q  <= count_q + CW'(push) - CW'(pop);
            filled_q <= filled_q + CW'(fill_en) - CW'(pop);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!flush && push && tail_idx == IW'(g)) tag_q[g]  <= push_tag;
            if (!flush && fill_en && fill_idx == IW'(g)) data_q[g] <= fill_data;
        end
    end

    // R5: a push never lands on a full FIFO
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R9: the controller only takes the head once its data is present
    a_r9_pop_needs_data: assert property (@(posedge clk) disable iff (rst)
        pop |-> (filled_q != '0));
    // R6: arriving data always belongs to an entry still waiting for it
    a_r6_fill_has_slot: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> (filled_q < count_q));
    a_r5_filled_le_count: assert property (@(posedge clk) disable iff (rst)
        filled_q <= count_q);

endmodule

// File: rtl/sbp_rsp_router.sv
module sbp_rsp_router import sbp_pkg::*; #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rsp_valid,
    input  logic          demand_out,
    input  logic          flush,
    input  logic [CW-1:0] pending,
    output sbp_rsp_e      kind
);
    logic [CW-1:0] stale_q;

    always_comb begin
        if (!rsp_valid)          kind = RSP_NONE;
        else if (stale_q != '0)  kind = RSP_DROP;
        else if (demand_out)     kind = RSP_DEMAND;
        else                     kind = RSP_PREF;
    end

    always_ff @(posedge clk) begin
        if (rst) stale_q <= '0;
        else stale_q <= stale_q - CW'(kind == RSP_DROP)
                      + (flush ? (pending - CW'(kind == RSP_PREF)) : '0);
    end

    // R6: a new flush only happens once older stale replies have drained
    a_r6_flush_clean: assert property (@(posedge clk) disable iff (rst)
        flush |-> (stale_q == '0));

endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher import sbp_pkg::*; #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              miss_ready,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [DATA_W-1:0] fill_data,
    output logic              fill_from_buf,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              mem_req_prefetch,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    localparam int CW = cnt_bits(DEPTH);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              from_buf;
    } fill_t;

    sbp_state_e        state_q;
    logic [ADDR_W-1:0] cur_q, pf_next_q;
    logic              pf_on_q;
    fill_t             fill_q;
    logic              fill_v_q;

    logic [CW-1:0]     count, filled;
    logic              full;
    logic [ADDR_W-1:0] head_tag;
    logic [DATA_W-1:0] head_data;
    sbp_rsp_e          rsp_kind;

    logic accept, head_hit, flush, dem_req, pf_req, pf_take, pop;

    assign miss_ready = (state_q == ST_IDLE);
    assign accept     = miss_valid && miss_ready;
    assign head_hit   = (count != '0) && (head_tag == miss_addr);
    assign flush      = accept && !head_hit;
    assign dem_req    = (state_q == ST_DEMREQ);
    assign pf_req     = pf_on_q && !full && !dem_req && !flush;
    assign pf_take    = pf_req && mem_req_ready;
    assign pop        = (state_q == ST_BUFWAIT) && (filled != '0);

    assign mem_req_valid    = dem_req || pf_req;
    assign mem_req_addr     = dem_req ? cur_q : pf_next_q;
    assign mem_req_prefetch = !dem_req;

    assign fill_valid    = fill_v_q;
    assign fill_addr     = fill_q.addr;
    assign fill_data     = fill_q.data;
    assign fill_from_buf = fill_q.from_buf;

    sbp_entry_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (pf_take),
        .push_tag  (pf_next_q),
        .fill_en   (rsp_kind == RSP_PREF),
        .fill_data (mem_rsp_data),
        .pop       (pop),
        .count     (count),
        .filled    (filled),
        .full      (full),
        .head_tag  (head_tag),
        .head_data (head_data)
    );

    sbp_rsp_router #(.CW(CW)) u_router (
        .clk        (clk),
        .rst        (rst),
        .rsp_valid  (mem_rsp_valid),
        .demand_out (state_q == ST_DEMWAIT),
        .flush      (flush),
        .pending    (count - filled),
        .kind       (rsp_kind)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cur_q     <= '0;
            pf_next_q <= '0;
            pf_on_q   <= 1'b0;
            fill_q    <= '0;
            fill_v_q  <= 1'b0;
        end else begin
            fill_v_q <= 1'b0;
            if (pf_take) pf_next_q <= pf_next_q + 1'b1;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    cur_q <= miss_addr;
                    if (head_hit) begin
                        state_q <= ST_BUFWAIT;
                    end else begin
                        state_q   <= ST_DEMREQ;
                        pf_next_q <= miss_addr + 1'b1;
                        pf_on_q   <= 1'b1;
                    end
                end
                ST_BUFWAIT: if (pop) begin
                    state_q  <= ST_IDLE;
                    fill_q   <= '{addr: cur_q, data: head_data, from_buf: 1'b1};
                    fill_v_q <= 1'b1;
                end
                ST_DEMREQ: if (mem_req_ready) state_q <= ST_DEMWAIT;
                ST_DEMWAIT: if (rsp_kind == RSP_DEMAND) begin
                    state_q  <= ST_IDLE;
                    fill_q   <= '{addr: cur_q, data: mem_rsp_data, from_buf: 1'b0};
                    fill_v_q <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R1: quiet ports after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (miss_ready && !fill_valid && !mem_req_valid));
    // R2: a non-matching miss puts its demand read on the port next cycle
    a_r2_demand_next: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && miss_ready && !head_hit) |=>
            (mem_req_valid && !mem_req_prefetch && mem_req_addr == $past(miss_addr)));
    // R2: an untaken demand read stays put
    a_r2_demand_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_prefetch && !mem_req_ready) |=>
            (mem_req_valid && !mem_req_prefetch && $stable(mem_req_addr)));
    // R4: taken prefetches run in sequence
    a_r4_sequential: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready && mem_req_prefetch) |=>
            (!(mem_req_valid && mem_req_prefetch) ||
             mem_req_addr == ADDR_W'($past(mem_req_addr) + 1'b1)));
    // R7: demand data goes straight to the fill port
    a_r7_demand_fill: assert property (@(posedge clk) disable iff (rst)
        (rsp_kind == RSP_DEMAND) |=>
            (fill_valid && !fill_from_buf && fill_data == $past(mem_rsp_data)));
    // R8: a head match never produces a demand read
    a_r8_hit_no_demand: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && miss_ready && head_hit) |=> !(mem_req_valid && !mem_req_prefetch));
    // R10: one miss in service at a time
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && miss_ready) |=> (!miss_ready && !fill_valid));
    a_r10_single_fill: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> !fill_valid);

endmodule

// File: tb/stream_prefetcher_test.sv
module stream_prefetcher_test;
    localparam int DEPTH  = 4;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int LAT    = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic miss_valid = 1'b0;
    logic [ADDR_W-1:0] miss_addr = '0;
    logic miss_ready, fill_valid, fill_from_buf;
    logic [ADDR_W-1:0] fill_addr, mem_req_addr;
    logic [DATA_W-1:0] fill_data;
    logic mem_req_valid, mem_req_prefetch;
    logic mem_req_ready = 1'b0;
    logic mem_rsp_valid = 1'b0;
    logic [DATA_W-1:0] mem_rsp_data = '0;

    always #2 clk = ~clk;

    stream_prefetcher #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .fill_from_buf(fill_from_buf),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_prefetch(mem_req_prefetch), .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0;
    bit finished = 0, running = 0, throttle = 0;

    // stimulus script
    int script_addr[$], script_gap[$];
    int gap_left = 0;

    // reference model
    int ent_addr[$], ent_arr[$];
    int next_pf = 0, cur = 0, acc = 0, exp_fill = -1, dem_from = 0, epoch = 0;
    bit pf_on = 0, busy = 0, hit_mode = 0, dem_wait = 0;
    int mq_addr[$], mq_kind[$], mq_epoch[$], mq_due[$];
    int buf_hits = 0, mem_fills = 0;

    function automatic logic [DATA_W-1:0] pat(input int a);
        logic [15:0] s;
        s = a[15:0];
        return {s, ~s};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // per-cycle driver and comparison against the model
    initial begin
        forever begin
            @(negedge clk);
            if (running) begin
                // fill port: R7 R8 R9 R10 R6
                if (fill_valid) begin
                    chk(busy, "R10", "fill without miss", 1, 0);
                    chk(cyc == exp_fill, hit_mode ? "R9" : "R7", "fill cycle", cyc, exp_fill);
                    chk(int'(fill_addr) == cur, "R7", "fill_addr", fill_addr, cur);
                    chk(fill_data == pat(cur), "R6", "fill_data", fill_data, pat(cur));
                    chk(fill_from_buf == hit_mode, "R8", "fill_from_buf", fill_from_buf, hit_mode);
                    if (hit_mode) begin
                        void'(ent_addr.pop_front()); void'(ent_arr.pop_front());
                        buf_hits++;
                    end else mem_fills++;
                    busy = 0; exp_fill = -1;
                end else if (busy && exp_fill >= 0 && cyc > exp_fill) begin
                    chk(0, hit_mode ? "R9" : "R7", "fill missing", 0, 1);
                    exp_fill = -1;
                end
                chk(miss_ready == !busy, "R10", "miss_ready", miss_ready, !busy);

                // present next miss
                miss_valid = 0;
                if (!busy && script_addr.size() > 0 && gap_left == 0) begin
                    int a;
                    a = script_addr.pop_front();
                    gap_left = script_gap.pop_front();
                    miss_valid = 1; miss_addr = ADDR_W'(a);
                    busy = 1; cur = a; acc = cyc + 1;
                    hit_mode = (ent_addr.size() > 0) && (ent_addr[0] == a);
                    exp_fill = -1;
                    if (hit_mode) begin
                        if (ent_arr[0] >= 0) exp_fill = ((acc > ent_arr[0]) ? acc : ent_arr[0]) + 1;
                    end else begin
                        ent_addr.delete(); ent_arr.delete();
                        epoch++; next_pf = (a + 1) & 16'hFFFF; pf_on = 1;
                        dem_wait = 1; dem_from = acc;
                    end
                end else if (!busy && gap_left > 0) gap_left--;

                // memory responses, in order
                mem_rsp_valid = 0;
                if (mq_due.size() > 0 && mq_due[0] <= cyc + 1) begin
                    int a, k, e, t;
                    a = mq_addr.pop_front(); k = mq_kind.pop_front();
                    e = mq_epoch.pop_front(); void'(mq_due.pop_front());
                    t = cyc + 1;
                    mem_rsp_valid = 1; mem_rsp_data = pat(a);
                    if (k == 0) exp_fill = t;
                    else if (e == epoch) begin
                        for (int i = 0; i < ent_addr.size(); i++) begin
                            if (ent_arr[i] < 0) begin
                                ent_arr[i] = t;
                                if (i == 0 && busy && hit_mode && exp_fill < 0)
                                    exp_fill = ((acc > t) ? acc : t) + 1;
                                break;
                            end
                        end
                    end
                end

                mem_req_ready = throttle ? ((cyc % 3) != 0) : 1'b1;
                #1;
                // request port: R2 R3 R4 R5 R11 R1
                if (dem_wait) begin
                    if (cyc >= dem_from) begin
                        chk(mem_req_valid && !mem_req_prefetch, "R2", "demand shown",
                            {mem_req_valid, mem_req_prefetch}, 2);
                        chk(int'(mem_req_addr) == cur, "R2", "demand addr", mem_req_addr, cur);
                    end else
                        chk(!mem_req_valid, "R3", "request during flush", mem_req_valid, 0);
                    if (mem_req_valid && mem_req_prefetch)
                        chk(0, "R3", "prefetch while demand waits", 1, 0);
                end else begin
                    bit want;
                    want = pf_on && (ent_addr.size() < DEPTH);
                    chk((mem_req_valid && mem_req_prefetch) == want, want ? "R11" : "R5",
                        "prefetch shown", mem_req_valid, want);
                    if (!pf_on) chk(!mem_req_valid, "R1", "request before first miss", mem_req_valid, 0);
                    if (mem_req_valid && mem_req_prefetch)
                        chk(int'(mem_req_addr) == next_pf, "R4", "prefetch addr", mem_req_addr, next_pf);
                end
                if (mem_req_valid && mem_req_ready) begin
                    mq_addr.push_back(int'(mem_req_addr));
                    mq_kind.push_back(mem_req_prefetch ? 1 : 0);
                    mq_epoch.push_back(epoch);
                    mq_due.push_back(cyc + 1 + LAT);
                    if (!mem_req_prefetch) dem_wait = 0;
                    else begin
                        ent_addr.push_back(int'(mem_req_addr)); ent_arr.push_back(-1);
                        next_pf = (next_pf + 1) & 16'hFFFF;
                    end
                end
            end
        end
    end

    task automatic add_run(input int base, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            script_addr.push_back((base + i) & 16'hFFFF);
            script_gap.push_back(gap);
        end
    endtask

    task automatic add_one(input int a, input int gap);
        script_addr.push_back(a); script_gap.push_back(gap);
    endtask

    task automatic drain();
        while (script_addr.size() > 0 || busy || gap_left > 0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        int h0, m0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(miss_ready == 1'b1, "R1", "reset miss_ready", miss_ready, 1);
        chk(fill_valid == 1'b0, "R1", "reset fill_valid", fill_valid, 0);
        chk(mem_req_valid == 1'b0, "R1", "reset mem_req_valid", mem_req_valid, 0);
        running = 1;

        // back-to-back sequential stream: hits on entries still in flight (R9)
        h0 = buf_hits; m0 = mem_fills;
        add_run(16'h0100, 20, 0); drain();
        chk(buf_hits - h0 == 19, "R8", "stream A buffer hits", buf_hits - h0, 19);
        chk(mem_fills - m0 == 1, "R7", "stream A memory fills", mem_fills - m0, 1);

        // spaced sequential stream: hits on entries already filled; R12 depth 4
        h0 = buf_hits; m0 = mem_fills;
        add_run(16'h0200, 12, 6); drain();
        chk(buf_hits - h0 == 11, "R8", "stream B buffer hits", buf_hits - h0, 11);
        chk(mem_fills - m0 == 1, "R12", "stream B memory fills", mem_fills - m0, 1);

        // jumps with prefetches in flight and a throttled port (R3 R6)
        throttle = 1;
        h0 = buf_hits; m0 = mem_fills;
        add_one(16'h0300, 0); add_one(16'h0500, 0); add_one(16'h0301, 0);
        add_one(16'h0302, 2); add_one(16'h07FF, 0); add_one(16'h0800, 0);
        add_one(16'h0900, 0); add_one(16'h0901, 3);
        drain();
        chk(buf_hits - h0 == 3, "R6", "jump buffer hits", buf_hits - h0, 3);
        chk(mem_fills - m0 == 5, "R2", "jump memory fills", mem_fills - m0, 5);
        throttle = 0;

        // address wrap (R4)
        h0 = buf_hits;
        add_run(16'hFFFD, 6, 1); drain();
        chk(buf_hits - h0 == 5, "R4", "wrap buffer hits", buf_hits - h0, 5);

        running = 0;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "R10", "watchdog expired", 0, 1);
        finish_run();
    end

endmodule